// File: doc/BRIEF.md
# Pipelined Bus Response Agent Sequencer

This block is the target side of a split-phase, pipelined processor bus. It watches the request strobe together with a request-type bit, which tells writes apart from reads. It then produces the rest of the transaction at fixed clock offsets. For a write, it raises target-ready, accepts the write word when the master is allowed to send it, and releases target-ready again. For both kinds, it samples the snoop hit-modified input and drives a one-clock code on the 3-bit response bus. For a read, it also drives data-ready and the data word in the same clock as the response.

All bus strobes are active low. The sequencer tracks one transaction at a time. A request strobe that arrives while a transaction is outstanding is not queued: it is reported on `proto_err`. A master data-ready that comes before it is allowed is also reported on `proto_err`. Clock numbers below count from the clock in which the request strobe is low, which is clock 0.

Top module: `resp_agent_seq`

## Requirements
- R1: With `rst_n` low at a rising edge (synchronous reset), from the next clock `tgt_rdy_n`, `tgt_dat_rdy_n` and `resp_n` are all high, `wr_word_vld` and `proto_err` are low, and the sequencer is idle. A transaction that was under way produces no further strobe.
- R2: While idle, `bus_req_n` low starts a transaction. It is a write if `req_wr_n` is low in the same clock and a read otherwise.
- R3: For a write, `tgt_rdy_n` goes low in clock 3.
- R4: If `busy_n` is high in clock 3, `tgt_rdy_n` is low for exactly clocks 3 and 4 and is high again in clock 5.
- R5: If `busy_n` is low in clock 3, `tgt_rdy_n` stays low until the master's data-ready is accepted in some clock m, and goes high in clock m+1.
- R6: A low `mst_rdy_n` in clock m is accepted only during a write, only once per write, and only if clock m-2 had `tgt_rdy_n` low and `busy_n` high.
  - When it is accepted, `wr_word` holds the `mst_data` of clock m and `wr_word_vld` is high in clock m+1 for one clock.
  - When it is not accepted, nothing is captured and `proto_err` is high in clock m+1.
- R7: `snoop_mod_n` is sampled in clock 5. The response appears on `resp_n` in clock 6 for exactly one clock, and `resp_n` idles at 3'b111 otherwise.
- R8: The response code (pin values, active low) is chosen as follows:
  - write with `snoop_mod_n` high: no-data, 3'b100;
  - any request with `snoop_mod_n` low: implicit-writeback, 3'b010;
  - read with `snoop_mod_n` high: normal-data, 3'b001.
- R9: For a read with normal-data response, `tgt_dat_rdy_n` is low and `tgt_data` equals the `rd_word` of clock 0, both in clock 6 only. No read data is driven on an implicit-writeback response.
- R10: `bus_req_n` low while a transaction is outstanding is ignored. `proto_err` is high for one clock in the following clock, and the outstanding transaction is unaffected.
- R11: A read completes after clock 6. A write completes after the later of clock 6 and the clock that shows `wr_word_vld`. A new request is accepted in the clock right after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req_n | input | 1 | Request strobe, active low |
| req_wr_n | input | 1 | Request type, low means write |
| snoop_mod_n | input | 1 | Snoop hit-modified, active low |
| busy_n | input | 1 | Data-bus busy from the write master, active low |
| mst_rdy_n | input | 1 | Write data-ready from the master, active low |
| mst_data | input | 64 | Write data from the master |
| rd_word | input | 64 | Read data, sampled with the request |
| tgt_rdy_n | output | 1 | Target-ready strobe, active low |
| resp_n | output | 3 | Response code, active low, idle 3'b111 |
| tgt_dat_rdy_n | output | 1 | Read data-ready strobe, active low |
| tgt_data | output | 64 | Read data word, zero when not driven |
| wr_word | output | 64 | Last accepted write word |
| wr_word_vld | output | 1 | One-clock pulse, a new write word was accepted |
| proto_err | output | 1 | One-clock pulse for a bus protocol violation |

## Verification
Every result of this block is due a fixed number of clocks after a stimulus:
- target-ready three clocks after the request;
- the response and read data six clocks after it;
- a captured write word one clock after the accepted data-ready;
- an error flag one clock after the offending strobe.

The bench schedules each transaction at an absolute clock number and, at the same moment, files the expected strobe values at the clocks where they are due. It samples on the falling edge and, in every clock with no filed item, also demands the idle level of every strobe. A strobe that comes early, comes late or lasts too long is therefore caught.

// File: rtl/resp_agent_pkg.sv
// Package: shared response codes for the response agent sequencer.
// The codes are logical (active high); the top inverts them onto the pins.
package resp_agent_pkg;

    typedef enum logic [2:0] {
        RC_IDLE   = 3'b000,
        RC_NODATA = 3'b011,
        RC_WBACK  = 3'b101,
        RC_NORMAL = 3'b110
    } resp_code_e;

endpackage

// File: rtl/ra_txn_track.sv
// Transaction tracker: accepts one request at a time, records its type and
// counts clocks since the request clock (count 1 in the clock after it).
// Assumes: the top raises txn_done for one clock when the transaction is over.
// A request strobe seen while busy is reported on ovl_req, never queued.
module ra_txn_track #(
    parameter int CNT_W   = 3,
    parameter int CNT_MAX = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req_n,
    input  logic             req_wr_n,
    input  logic             txn_done,
    output logic             act,
    output logic             is_wr,
    output logic [CNT_W-1:0] cnt,
    output logic             start,
    output logic             ovl_req
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);

    logic             act_q;
    logic             wr_q;
    logic [CNT_W-1:0] cnt_q;

    // accept only when idle; a request while busy is an overlap error
    assign start   = !bus_req_n && !act_q;
    assign ovl_req = !bus_req_n && act_q;

    // hold the activity flag, the request type and the saturating clock count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            wr_q  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            act_q <= 1'b1;
            wr_q  <= !req_wr_n;
            cnt_q <= CNT_W'(1);
        end else if (act_q) begin
            if (txn_done) begin
                act_q <= 1'b0;
                cnt_q <= '0;
            end else if (cnt_q != SAT) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign act   = act_q;
    assign is_wr = wr_q;
    assign cnt   = cnt_q;

    assert_done_only_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |-> act_q);

    assert_count_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !txn_done && cnt_q != SAT) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/ra_wr_handshake.sv
// Write handshake: raises target-ready at a fixed offset and tracks the
// ready/busy pair. It accepts one master data-ready per write, only two clocks
// after a clock that had target-ready active with busy inactive.
// Release is early (after two clocks) when busy was inactive in the first
// target-ready clock; otherwise it follows the accepted data-ready.
module ra_wr_handshake #(
    parameter int DW       = 64,
    parameter int CNT_W    = 3,
    parameter int TRDY_OFS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             is_wr,
    input  logic [CNT_W-1:0] cnt,
    input  logic             busy_n,
    input  logic             mst_rdy_n,
    input  logic [DW-1:0]    mst_data,
    output logic             trdy,
    output logic             got,
    output logic             early_rdy,
    output logic [DW-1:0]    word,
    output logic             word_vld
);

    localparam logic [CNT_W-1:0] RAISE_AT = CNT_W'(TRDY_OFS - 1);
    localparam logic [CNT_W-1:0] FIRST_AT = CNT_W'(TRDY_OFS);
    localparam logic [CNT_W-1:0] DROP_AT  = CNT_W'(TRDY_OFS + 1);

    logic          trdy_q;
    logic          fast_rel_q;
    logic          ok1_q;
    logic          ok2_q;
    logic          got_q;
    logic [DW-1:0] word_q;
    logic          vld_q;
    logic          accept;

    // a data-ready is taken once per write, two clocks after ready-and-not-busy
    assign accept    = act && is_wr && !got_q && ok2_q && !mst_rdy_n;
    assign early_rdy = !mst_rdy_n && !accept;

    // target-ready: raise at the offset, drop early or after the accepted data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trdy_q <= 1'b0;
        end else if (act && is_wr && !trdy_q && !got_q && cnt == RAISE_AT) begin
            trdy_q <= 1'b1;
        end else if (trdy_q && ((fast_rel_q && cnt == DROP_AT) || accept)) begin
            trdy_q <= 1'b0;
        end
    end

    // remember whether busy was inactive in the first target-ready clock
    always_ff @(posedge clk) begin
        if (!rst_n || !act) begin
            fast_rel_q <= 1'b0;
        end else if (trdy_q && cnt == FIRST_AT) begin
            fast_rel_q <= busy_n;
        end
    end

    // two-stage record of the ready-and-not-busy condition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok1_q <= 1'b0;
            ok2_q <= 1'b0;
        end else begin
            ok1_q <= trdy_q && busy_n;
            ok2_q <= ok1_q;
        end
    end

    // capture the write word and flag it for one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_q  <= 1'b0;
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= accept;
            if (!act) begin
                got_q <= 1'b0;
            end else if (accept) begin
                got_q <= 1'b1;
            end
            if (accept) begin
                word_q <= mst_data;
            end
        end
    end

    assign trdy     = trdy_q;
    assign got      = got_q;
    assign word     = word_q;
    assign word_vld = vld_q;

    assert_trdy_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trdy_q |-> (act && is_wr));

    assert_accept_after_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> $past(trdy_q, 3));

    assert_fast_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy_q && fast_rel_q && cnt == DROP_AT) |=> !trdy_q);

    assert_single_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);

endmodule

// File: rtl/ra_resp_drive.sv
// Response driver: samples snoop hit-modified at a fixed offset and, one
// clock later, drives a single-clock response code. For a read without a
// modified hit, it drives data-ready and the word latched at request time.
// Assumes: cnt counts from 1 in the clock after the request clock.
module ra_resp_drive
    import resp_agent_pkg::*;
#(
    parameter int DW        = 64,
    parameter int CNT_W     = 3,
    parameter int SNOOP_OFS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             is_wr,
    input  logic [CNT_W-1:0] cnt,
    input  logic             start,
    input  logic             snoop_mod_n,
    input  logic [DW-1:0]    rd_word,
    output resp_code_e       resp,
    output logic             rd_rdy,
    output logic [DW-1:0]    rd_data,
    output logic             sent
);

    localparam logic [CNT_W-1:0] SNOOP_AT = CNT_W'(SNOOP_OFS);

    resp_code_e    resp_q;
    logic          rdy_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] rbuf_q;
    logic          sent_q;
    logic          fire;

    assign fire = act && !sent_q && cnt == SNOOP_AT;

    // latch the read word in the request clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf_q <= '0;
        end else if (start) begin
            rbuf_q <= rd_word;
        end
    end

    // pick the code from the snoop sample; every strobe lasts one clock
    always_ff @(posedge clk) begin
        if (!rst_n || !fire) begin
            resp_q <= RC_IDLE;
            rdy_q  <= 1'b0;
            data_q <= '0;
        end else if (!snoop_mod_n) begin
            resp_q <= RC_WBACK;
            rdy_q  <= 1'b0;
            data_q <= '0;
        end else if (is_wr) begin
            resp_q <= RC_NODATA;
            rdy_q  <= 1'b0;
            data_q <= '0;
        end else begin
            resp_q <= RC_NORMAL;
            rdy_q  <= 1'b1;
            data_q <= rbuf_q;
        end
    end

    // note that the response of the current transaction went out
    always_ff @(posedge clk) begin
        if (!rst_n || !act) begin
            sent_q <= 1'b0;
        end else if (fire) begin
            sent_q <= 1'b1;
        end
    end

    assign resp    = resp_q;
    assign rd_rdy  = rdy_q;
    assign rd_data = data_q;
    assign sent    = sent_q;

    assert_resp_one_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_q != RC_IDLE) |=> (resp_q == RC_IDLE));

    assert_data_with_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |-> (resp_q == RC_NORMAL && !is_wr));

    assert_resp_in_txn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_q != RC_IDLE) |-> (act && $past(act)));

endmodule

// File: rtl/resp_agent_seq.sv
// Top of the response agent sequencer. It ties the tracker, the write
// handshake and the response driver together, decides when a transaction is
// complete and registers the protocol error pulse. All pins are active low
// except data, the capture pulse and the error flag.
module resp_agent_seq
    import resp_agent_pkg::*;
#(
    parameter int DW        = 64,
    parameter int TRDY_OFS  = 3,
    parameter int SNOOP_OFS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req_n,
    input  logic          req_wr_n,
    input  logic          snoop_mod_n,
    input  logic          busy_n,
    input  logic          mst_rdy_n,
    input  logic [DW-1:0] mst_data,
    input  logic [DW-1:0] rd_word,
    output logic          tgt_rdy_n,
    output logic [2:0]    resp_n,
    output logic          tgt_dat_rdy_n,
    output logic [DW-1:0] tgt_data,
    output logic [DW-1:0] wr_word,
    output logic          wr_word_vld,
    output logic          proto_err
);

    localparam int CNT_MAX = SNOOP_OFS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             act, is_wr, start, ovl_req, txn_done;
    logic [CNT_W-1:0] cnt;
    logic             trdy, got, early_rdy, rd_rdy, sent;
    resp_code_e       resp;
    logic             err_q;

    ra_txn_track #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_track (
        .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .req_wr_n(req_wr_n),
        .txn_done(txn_done), .act(act), .is_wr(is_wr), .cnt(cnt),
        .start(start), .ovl_req(ovl_req)
    );

    ra_wr_handshake #(.DW(DW), .CNT_W(CNT_W), .TRDY_OFS(TRDY_OFS)) u_wr (
        .clk(clk), .rst_n(rst_n), .act(act), .is_wr(is_wr), .cnt(cnt),
        .busy_n(busy_n), .mst_rdy_n(mst_rdy_n), .mst_data(mst_data),
        .trdy(trdy), .got(got), .early_rdy(early_rdy),
        .word(wr_word), .word_vld(wr_word_vld)
    );

    ra_resp_drive #(.DW(DW), .CNT_W(CNT_W), .SNOOP_OFS(SNOOP_OFS)) u_resp (
        .clk(clk), .rst_n(rst_n), .act(act), .is_wr(is_wr), .cnt(cnt),
        .start(start), .snoop_mod_n(snoop_mod_n), .rd_word(rd_word),
        .resp(resp), .rd_rdy(rd_rdy), .rd_data(tgt_data), .sent(sent)
    );

    // a read ends with its response; a write also needs its data and a released target-ready
    assign txn_done = act && sent && (!is_wr || (got && !trdy));

    // register any protocol violation as a one-clock pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= ovl_req || early_rdy;
        end
    end

    assign tgt_rdy_n     = !trdy;
    assign resp_n        = ~resp;
    assign tgt_dat_rdy_n = !rd_rdy;
    assign proto_err     = err_q;

    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> (tgt_rdy_n && tgt_dat_rdy_n && resp_n == 3'b111));

    assert_overlap_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act) && !$past(bus_req_n)) |-> proto_err);

endmodule

// File: tb/sim_resp_agent_seq.sv
`timescale 1ns/1ps
module sim_resp_agent_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req_n = 1'b1, req_wr_n = 1'b1, snoop_mod_n = 1'b1;
    logic        busy_n = 1'b1, mst_rdy_n = 1'b1;
    logic [63:0] mst_data = '0, rd_word = '0;
    logic        tgt_rdy_n, tgt_dat_rdy_n, wr_word_vld, proto_err;
    logic [2:0]  resp_n;
    logic [63:0] tgt_data, wr_word;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int end_c = 0;

    localparam logic [63:0] RD_FILL = 64'h5A5A_0F0F_A5A5_F0F0;

    resp_agent_seq u0 (
        .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .req_wr_n(req_wr_n),
        .snoop_mod_n(snoop_mod_n), .busy_n(busy_n), .mst_rdy_n(mst_rdy_n),
        .mst_data(mst_data), .rd_word(rd_word), .tgt_rdy_n(tgt_rdy_n),
        .resp_n(resp_n), .tgt_dat_rdy_n(tgt_dat_rdy_n), .tgt_data(tgt_data),
        .wr_word(wr_word), .wr_word_vld(wr_word_vld), .proto_err(proto_err)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // stimulus plan, keyed by clock number
    bit          pl_req[int], pl_wr[int], pl_hit[int], pl_busy[int], pl_rdy[int], pl_rst[int];
    logic [63:0] pl_md[int], pl_rd[int];

    // scoreboard items: signal 0 trdy,1 resp,2 rd rdy,3 rd data,4 vld,5 wr word,6 err
    typedef struct {
        int          cyc;
        int          sig;
        logic [63:0] val;
        string       req;
    } exp_t;
    exp_t sb[$];

    task automatic want(input int c, input int s, input logic [63:0] v, input string r);
        exp_t e;
        e.cyc = c; e.sig = s; e.val = v; e.req = r;
        sb.push_back(e);
    endtask

    // write: request c0, busy low for bl clocks from c0+3, master data when permitted
    task automatic sch_write(input int c0, input bit hit, input int bl,
                             input logic [63:0] d, input bit early, output int nxt);
        int m, last;
        pl_req[c0] = 1'b1; pl_wr[c0] = 1'b1;
        for (int k = 0; k < bl; k++) pl_busy[c0 + 3 + k] = 1'b1;
        if (hit) pl_hit[c0 + 5] = 1'b1;
        m = c0 + 5 + bl;
        pl_rdy[m] = 1'b1; pl_md[m] = d;
        if (early) begin
            pl_rdy[c0 + 4] = 1'b1; pl_md[c0 + 4] = ~d;
            want(c0 + 5, 6, 64'd1, "R6 early data-ready");
        end
        last = (bl == 0) ? c0 + 4 : m;
        want(c0 + 3, 0, 64'd0, "R3 target-ready offset");
        for (int k = c0 + 4; k <= last; k++) want(k, 0, 64'd0, (bl == 0) ? "R4 early release" : "R5 held release");
        want(m + 1, 4, 64'd1, "R6 capture pulse");
        want(m + 1, 5, d, "R6 captured word");
        want(c0 + 6, 1, hit ? 64'd2 : 64'd4, hit ? "R8 writeback code" : "R2 R7 R8 no-data code");
        nxt = (m + 2 > c0 + 7) ? m + 2 : c0 + 7;
    endtask

    // read: request c0 with word d, response and data in c0+6
    task automatic sch_read(input int c0, input bit hit, input logic [63:0] d,
                            input string tag, output int nxt);
        pl_req[c0] = 1'b1; pl_rd[c0] = d;
        if (hit) pl_hit[c0 + 5] = 1'b1;
        want(c0 + 6, 1, hit ? 64'd2 : 64'd1, tag);
        if (!hit) begin
            want(c0 + 6, 2, 64'd0, "R9 read data-ready with response");
            want(c0 + 6, 3, d, "R9 read word");
        end
        nxt = c0 + 7;
    endtask

    function automatic logic [63:0] obs(input int s);
        case (s)
            0: return {63'd0, tgt_rdy_n};
            1: return {61'd0, resp_n};
            2: return {63'd0, tgt_dat_rdy_n};
            3: return tgt_data;
            4: return {63'd0, wr_word_vld};
            5: return wr_word;
            default: return {63'd0, proto_err};
        endcase
    endfunction

    function automatic logic [63:0] idle_val(input int s);
        case (s)
            0: return 64'd1;
            1: return 64'd7;
            2: return 64'd1;
            default: return 64'd0;
        endcase
    endfunction

    function automatic string idle_req(input int s);
        case (s)
            0: return "R4 R5 target-ready idle";
            1: return "R7 response idle";
            2: return "R9 read strobe idle";
            4: return "R6 no capture";
            default: return "R10 no error";
        endcase
    endfunction

    // apply the plan for the current clock
    always @(negedge clk) begin
        rst_n       = !(cyc < 4 || pl_rst.exists(cyc));
        bus_req_n   = !pl_req.exists(cyc);
        req_wr_n    = !pl_wr.exists(cyc);
        snoop_mod_n = !pl_hit.exists(cyc);
        busy_n      = !pl_busy.exists(cyc);
        mst_rdy_n   = !pl_rdy.exists(cyc);
        mst_data    = pl_md.exists(cyc) ? pl_md[cyc] : 64'hFFFF_0000_FFFF_0000;
        rd_word     = pl_rd.exists(cyc) ? pl_rd[cyc] : RD_FILL;
    end

    // monitor: pop due items, demand idle levels elsewhere
    always @(negedge clk) begin
        if (cyc >= 4) begin
            for (int s = 0; s < 7; s++) begin
                bit found;
                found = 1'b0;
                for (int i = sb.size() - 1; i >= 0; i--) begin
                    if (sb[i].cyc == cyc && sb[i].sig == s) begin
                        found = 1'b1;
                        n_chk++;
                        if (obs(s) !== sb[i].val) begin
                            n_bad++;
                            $display("FAIL %s clock %0d sig %0d actual %h expected %h",
                                     sb[i].req, cyc, s, obs(s), sb[i].val);
                        end
                        sb.delete(i);
                    end
                end
                if (!found && s != 3 && s != 5 && obs(s) !== idle_val(s)) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL %s clock %0d sig %0d actual %h expected %h",
                             idle_req(s), cyc, s, obs(s), idle_val(s));
                end
            end
        end
    end

    initial begin
        int c;
        // R1: reset state after the start-up reset
        for (int s = 0; s < 7; s++) if (s != 3 && s != 5) want(4, s, idle_val(s), "R1 reset state");
        c = 6;
        sch_write(c, 1'b0, 0, 64'h1111_2222_3333_4444, 1'b0, c);
        sch_write(c, 1'b1, 2, 64'h5555_6666_7777_8888, 1'b0, c);
        sch_read(c, 1'b0, 64'hCAFE_0001_BEEF_0002, "R2 R7 R8 normal-data code", c);
        sch_read(c, 1'b1, 64'h0BAD_0BAD_0BAD_0BAD, "R8 R9 writeback read, no data", c);
        sch_write(c, 1'b0, 1, 64'h9999_AAAA_BBBB_CCCC, 1'b1, c);
        sch_write(c, 1'b1, 0, 64'h0123_4567_89AB_CDEF, 1'b0, c);
        // R10: overlapping request is flagged and ignored
        pl_req[c + 2] = 1'b1; pl_wr[c + 2] = 1'b1;
        want(c + 3, 6, 64'd1, "R10 overlap error");
        sch_read(c, 1'b0, 64'hD00D_F00D_1234_5678, "R10 read unaffected", c);
        // R11: back-to-back read accepted in the clock after completion
        sch_read(c, 1'b0, 64'h4242_4242_0000_0001, "R11 back-to-back read", c);
        // R1: reset in the middle of a write
        pl_req[c] = 1'b1; pl_wr[c] = 1'b1; pl_rst[c + 2] = 1'b1;
        want(c + 3, 0, 64'd1, "R1 reset mid-write target-ready");
        want(c + 3, 1, 64'd7, "R1 reset mid-write response");
        want(c + 6, 1, 64'd7, "R1 no response after reset");
        sch_read(c + 4, 1'b0, 64'h7777_0000_7777_0000, "R1 read after reset", c);
        end_c = c + 8;
        while (cyc < end_c) @(posedge clk);
        @(negedge clk);
        if (sb.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 unmatched items actual %0d expected 0", sb.size());
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog expired actual %0d expected %0d", cyc, end_c);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule